// File: doc/BRIEF.md
# Packet burst segmentation scheduler

This block sits between a transmit word buffer and a packet-over-link framer. Packet words arrive 16 bits at a time. Each word carries a channel address and start-of-packet and end-of-packet flags. The block stores them in an internal buffer of 2048 words and decides when a burst may leave. Long packets are cut into bursts of a configured size. The output stream marks the first word of every burst, the last word of every burst, and the true last word of every packet.

The burst size is set in credits, and one credit is eight 16-bit words. The block has two launch policies, chosen by a mode bit:
- **Mode 0 (eager):** a burst goes out as soon as one whole credit is buffered, or as soon as an end-of-packet is buffered.
- **Mode 1 (holding):** data is held until one of these occurs:
  - a packet end is buffered;
  - a full maximum-length burst is buffered;
  - the channel address of the incoming words changes.

The configuration is sampled when each burst is launched. A setting of zero credits acts as one credit. In mode 0 any setting above 256 credits acts as 256 credits. Once a burst has started, its words leave on consecutive cycles with no gaps, because a burst is only launched for data already in the buffer.

Top module: `seg_sched`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1, and no word is emitted until a launch condition holds.
- R2: In mode 1 (cfg_mode=1), fewer buffered words than the burst length with no end-of-packet and no channel change produce no output; the arrival of the end-of-packet word launches the whole packet as one burst.
- R3: In mode 0 (cfg_mode=0), fewer than 8 buffered words with no end-of-packet produce no output. Eight buffered words launch a burst. A buffered end-of-packet launches a burst of any length, including a single word that carries start-of-burst, end-of-burst and end-of-packet together.
- R4: cfg_burst_len counts credits of 8 words, and the value 0 is treated as 1 credit (8 words).
- R5: In mode 1, a packet written without gaps leaves as bursts of exactly cfg_burst_len*8 words, except its last burst, which carries the remainder.
- R6: In mode 0, no burst exceeds the configured length. Every burst that does not end the packet is a whole number of credits.
- R7: Words leave in arrival order with unchanged data and channel. out_sob marks only the first word of each burst and out_eob only its last. out_eop appears only on the final word of a packet, never at a cut, and always together with out_eob.
- R8: When the input channel address changes, the words already buffered for the old channel leave as a burst of their own. That burst ends with out_eob, has no out_eop, and is complete before any word of the new channel is emitted.
- R9: When the buffer holds 2048 words, in_ready is 0. In mode 1, the full buffer is then launched as one burst, even below the burst length.
- R10: Once out_sob is seen, out_valid stays 1 on every cycle until out_eob, and the block never reads its buffer while it is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Buffer can accept a word |
| in_data | input | 16 | Input payload word |
| in_chan | input | 8 | Channel address of the input word |
| in_sop | input | 1 | Input word starts a packet |
| in_eop | input | 1 | Input word ends a packet |
| cfg_burst_len | input | 10 | Maximum burst length in credits of 8 words |
| cfg_mode | input | 1 | 0: eager launch; 1: holding launch |
| out_valid | output | 1 | Output word present |
| out_data | output | 16 | Output payload word |
| out_chan | output | 8 | Channel address of the output word |
| out_sop | output | 1 | Start-of-packet flag carried through |
| out_eop | output | 1 | Final word of a packet |
| out_sob | output | 1 | First word of a burst |
| out_eob | output | 1 | Last word of a burst |

## Verification
The following rules hold on every cycle and are checked there:
- the word stream inside a burst has no gaps;
- out_sob opens each burst and never appears inside one;
- out_eop always coincides with out_eob;
- the buffer is never read while it is empty;
- the output is silent right after reset.

Some behaviour only shows over whole scenarios, and the bench covers it by sending packets under both modes and comparing the recovered burst lengths with values computed from the configured credit size. That covers:
- when a burst is allowed to start;
- the exact segment lengths;
- the separation of a channel change;
- the forced launch of a full buffer.

// File: rtl/seg_pkg.sv
package seg_pkg;
    localparam int DATA_W           = 16;
    localparam int CH_W             = 8;
    localparam int BLEN_W           = 10;
    localparam int WORDS_PER_CREDIT = 8;
    localparam int CREDIT_SH        = $clog2(WORDS_PER_CREDIT);
    localparam int MAX_CR_EAGER     = 256;
    localparam int MAX_CR_HOLD      = 1023;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [CH_W-1:0]   chan;
        logic              sop;
        logic              eop;
    } word_t;

    typedef enum logic {RD_IDLE, RD_BURST} rd_state_e;

    // Effective burst length in credits: zero means one, clamp per mode.
    function automatic logic [BLEN_W-1:0] eff_credits(input logic [BLEN_W-1:0] req,
                                                      input logic mode);
        logic [BLEN_W-1:0] r;
        r = req;
        if (req == '0)
            r = BLEN_W'(1);
        else if (!mode && int'(req) > MAX_CR_EAGER)
            r = BLEN_W'(MAX_CR_EAGER);
        else if (mode && int'(req) > MAX_CR_HOLD)
            r = BLEN_W'(MAX_CR_HOLD);
        return r;
    endfunction
endpackage

// File: rtl/seg_fifo.sv
module seg_fifo
    import seg_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  word_t         wr_word,
    input  logic          rd_en,
    output word_t         head,
    output logic          head_bnd,
    output logic [CW-1:0] count,
    output logic [CW-1:0] term_cnt,
    output logic          full
);
    word_t             mem [DEPTH];
    logic [DEPTH-1:0]  bnd;
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic              have_last, last_eop;
    logic [CH_W-1:0]   last_chan;
    logic              set_bnd;
    logic              head_term;

    assign head     = mem[rd_ptr];
    assign head_bnd = bnd[rd_ptr];
    assign full     = (count == CW'(DEPTH));
    assign head_term = head.eop || head_bnd;

    // Mark the previous word as a channel-boundary terminator when the
    // channel switches while that word is still buffered after this cycle.
    always_comb begin
        set_bnd = wr_en && have_last && !last_eop
               && (wr_word.chan != last_chan)
               && (count > CW'(rd_en));
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bnd       <= '0;
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            count     <= '0;
            term_cnt  <= '0;
            have_last <= 1'b0;
            last_eop  <= 1'b0;
            last_chan <= '0;
        end else begin
            if (wr_en) begin
                bnd[wr_ptr] <= 1'b0;
                wr_ptr      <= wr_ptr + AW'(1);
                have_last   <= 1'b1;
                last_eop    <= wr_word.eop;
                last_chan   <= wr_word.chan;
            end
            if (set_bnd) begin
                bnd[wr_ptr - AW'(1)] <= 1'b1;
            end
            if (rd_en) begin
                rd_ptr <= rd_ptr + AW'(1);
            end
            count    <= count + CW'(wr_en) - CW'(rd_en);
            term_cnt <= term_cnt + CW'(wr_en && wr_word.eop) + CW'(set_bnd)
                      - CW'(rd_en && head_term);
        end
    end
endmodule

// File: rtl/seg_launch.sv
module seg_launch
    import seg_pkg::*;
#(
    parameter int CW = 12,
    parameter int LW = BLEN_W + CREDIT_SH
) (
    input  logic              mode,
    input  logic [BLEN_W-1:0] blen,
    input  logic [CW-1:0]     count,
    input  logic [CW-1:0]     term_cnt,
    input  logic              full,
    output logic              go,
    output logic [LW-1:0]     plen
);
    logic [31:0] lim_w, cnt_w, avail;
    logic        have_term, enough;

    always_comb begin
        lim_w     = 32'(eff_credits(blen, mode)) << CREDIT_SH;
        cnt_w     = 32'(count);
        have_term = (term_cnt != '0);
        // Eager mode only ever releases whole credits without a terminator.
        avail     = mode ? cnt_w : (cnt_w & ~32'(WORDS_PER_CREDIT - 1));
        enough    = mode ? (cnt_w >= lim_w) : (cnt_w >= 32'(WORDS_PER_CREDIT));
        go        = (count != '0) && (have_term || full || enough);
        // With a terminator buffered the burst stops at it or at the limit.
        plen      = (have_term || avail >= lim_w) ? LW'(lim_w) : LW'(avail);
    end
endmodule

// File: rtl/seg_sched.sv
module seg_sched
    import seg_pkg::*;
#(
    parameter int DEPTH = 2048
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CH_W-1:0]   in_chan,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [BLEN_W-1:0] cfg_burst_len,
    input  logic              cfg_mode,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [CH_W-1:0]   out_chan,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_sob,
    output logic              out_eob
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam int LW = BLEN_W + CREDIT_SH;

    word_t         wr_word, head;
    logic          wr_en, rd_en, head_bnd, full, go, last;
    logic [CW-1:0] fifo_count, term_cnt;
    logic [LW-1:0] plen, plen_q, sent_q;
    rd_state_e     state;

    assign in_ready = !full;
    assign wr_en    = in_valid && in_ready;
    assign wr_word  = '{data: in_data, chan: in_chan, sop: in_sop, eop: in_eop};
    assign rd_en    = (state == RD_BURST);
    assign last     = head.eop || head_bnd || (sent_q + LW'(1) == plen_q);

    seg_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_word  (wr_word),
        .rd_en    (rd_en),
        .head     (head),
        .head_bnd (head_bnd),
        .count    (fifo_count),
        .term_cnt (term_cnt),
        .full     (full)
    );

    seg_launch #(.CW(CW), .LW(LW)) u_launch (
        .mode     (cfg_mode),
        .blen     (cfg_burst_len),
        .count    (fifo_count),
        .term_cnt (term_cnt),
        .full     (full),
        .go       (go),
        .plen     (plen)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RD_IDLE;
            plen_q    <= '0;
            sent_q    <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_chan  <= '0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_sob   <= 1'b0;
            out_eob   <= 1'b0;
        end else begin
            out_valid <= rd_en;
            out_sob   <= rd_en && (sent_q == '0);
            out_eob   <= rd_en && last;
            out_eop   <= rd_en && head.eop;
            if (rd_en) begin
                out_data <= head.data;
                out_chan <= head.chan;
                out_sop  <= head.sop;
                sent_q   <= sent_q + LW'(1);
                if (last) state <= RD_IDLE;
            end else if (go) begin
                state  <= RD_BURST;
                plen_q <= plen;
                sent_q <= '0;
            end
        end
    end
endmodule

// File: rtl/seg_sched_chk.sv
module seg_sched_chk #(
    parameter int CW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          out_valid,
    input logic          out_sob,
    input logic          out_eob,
    input logic          out_eop,
    input logic          rd_en,
    input logic [CW-1:0] fifo_count
);
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);

    a_r10_no_gap: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_eob) |=> out_valid);

    a_r10_no_underflow: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (fifo_count != '0));

    a_r7_burst_opens_sob: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> out_sob);

    a_r7_no_inner_sob: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_eob) |=> !out_sob);

    a_r7_eop_closes_burst: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_eop) |-> out_eob);
endmodule

bind seg_sched seg_sched_chk #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .out_valid  (out_valid),
    .out_sob    (out_sob),
    .out_eob    (out_eob),
    .out_eop    (out_eop),
    .rd_en      (rd_en),
    .fifo_count (fifo_count)
);

// File: tb/seg_sched_test.sv
module seg_sched_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAXOBS     = 8192;

    typedef struct packed {
        logic        mode;
        logic [9:0]  blen;
        logic [7:0]  chan;
        logic [15:0] nw;
    } row_t;

    localparam row_t ROWS [0:6] = '{
        '{1'b1, 10'd0, 8'd1, 16'd20},    // R4 zero -> one credit, R5
        '{1'b1, 10'd2, 8'd2, 16'd40},    // R5
        '{1'b1, 10'd3, 8'd3, 16'd24},    // R5 exact fit
        '{1'b1, 10'd1, 8'd4, 16'd3},     // R5 short packet
        '{1'b0, 10'd1, 8'd5, 16'd20},    // R6
        '{1'b0, 10'd2, 8'd6, 16'd45},    // R6
        '{1'b1, 10'd5, 8'd7, 16'd100}    // R5
    };

    logic        clk = 1'b0, rst = 1'b1;
    logic        in_valid = 1'b0, in_ready;
    logic [15:0] in_data = '0;
    logic [7:0]  in_chan = '0;
    logic        in_sop = 1'b0, in_eop = 1'b0;
    logic [9:0]  cfg_burst_len = '0;
    logic        cfg_mode = 1'b0;
    logic        out_valid, out_sop, out_eop, out_sob, out_eob;
    logic [15:0] out_data;
    logic [7:0]  out_chan;

    logic [15:0] m_data [MAXOBS];
    logic [7:0]  m_chan [MAXOBS];
    logic        m_sob [MAXOBS];
    logic        m_eob [MAXOBS];
    logic        m_eop [MAXOBS];
    int n_obs = 0, n_tests = 0, n_fail = 0, cycles = 0;
    int seq = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_sched uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_chan(in_chan), .in_sop(in_sop), .in_eop(in_eop),
        .cfg_burst_len(cfg_burst_len), .cfg_mode(cfg_mode),
        .out_valid(out_valid), .out_data(out_data), .out_chan(out_chan),
        .out_sop(out_sop), .out_eop(out_eop), .out_sob(out_sob), .out_eob(out_eob)
    );

    always @(negedge clk) begin
        if (!rst && out_valid && n_obs < MAXOBS) begin
            m_data[n_obs] = out_data;
            m_chan[n_obs] = out_chan;
            m_sob[n_obs]  = out_sob;
            m_eob[n_obs]  = out_eob;
            m_eop[n_obs]  = out_eop;
            n_obs = n_obs + 1;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_tests = n_tests + 1;
            n_fail  = n_fail + 1;
            $display("FAIL R10 watchdog: actual %0d cycles expected completion", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests = n_tests + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] ch, input bit sop, input bit eop);
        in_data  = 16'(seq);
        in_chan  = ch;
        in_sop   = sop;
        in_eop   = eop;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        seq = seq + 1;
    endtask

    task automatic send(input logic [7:0] ch, input int n, input bit sop_first,
                        input bit eop_last);
        for (int i = 0; i < n; i++) push(ch, sop_first && i == 0, eop_last && i == n - 1);
    endtask

    task automatic wait_obs(input int target);
        for (int i = 0; i < 20000 && n_obs < target; i++) @(negedge clk);
    endtask

    function automatic int lim_words(input bit mode, input int blen);
        int cr;
        cr = (blen == 0) ? 1 : ((!mode && blen > 256) ? 256 : blen);
        return cr * 8;
    endfunction

    // Walk nw observed words from n0 and check order, markers, burst lengths.
    task automatic analyze(input int n0, input int nw, input int seq0,
                           input logic [7:0] ch, input bit exact, input int limw,
                           input bit has_eop, input string lreq);
        int bad_data = 0, bad_mark = 0, bad_len = 0, run = 0, worst = 0;
        check(n_obs >= n0 + nw, lreq, "word count", n_obs - n0, nw);
        for (int k = 0; k < nw && n0 + k < n_obs; k++) begin
            int idx = n0 + k;
            bit fin = (k == nw - 1);
            if (m_data[idx] != 16'(seq0 + k) || m_chan[idx] != ch) bad_data++;
            if (m_sob[idx] != (run == 0)) bad_mark++;
            if (m_eop[idx] != (has_eop && fin)) bad_mark++;
            if (fin && !m_eob[idx]) bad_mark++;
            run++;
            if (m_eob[idx]) begin
                if (exact) begin
                    if (fin ? (run != ((nw - 1) % limw) + 1) : (run != limw)) bad_len++;
                end else begin
                    if (run > limw || (!fin && run % 8 != 0)) bad_len++;
                end
                if (bad_len != 0 && worst == 0) worst = run;
                run = 0;
            end
        end
        check(bad_data == 0, "R7", "data/channel order errors", bad_data, 0);
        check(bad_mark == 0, "R7", "marker errors", bad_mark, 0);
        check(bad_len == 0, lreq, "burst length errors (first bad length)", worst, limw);
    endtask

    initial begin
        int n0, s0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
        repeat (10) @(negedge clk);
        check(n_obs == 0, "R1", "words emitted while idle", n_obs, 0);

        // Table of packets, R4/R5/R6/R7
        for (int r = 0; r < 7; r++) begin
            cfg_mode      = ROWS[r].mode;
            cfg_burst_len = ROWS[r].blen;
            n0 = n_obs;
            s0 = seq;
            send(ROWS[r].chan, int'(ROWS[r].nw), 1'b1, 1'b1);
            wait_obs(n0 + int'(ROWS[r].nw));
            repeat (4) @(negedge clk);
            analyze(n0, int'(ROWS[r].nw), s0, ROWS[r].chan, ROWS[r].mode,
                    lim_words(ROWS[r].mode, int'(ROWS[r].blen)), 1'b1,
                    ROWS[r].mode ? (ROWS[r].blen == 0 ? "R4" : "R5") : "R6");
        end

        // R2: holding mode waits for the packet end
        cfg_mode = 1'b1; cfg_burst_len = 10'd4;
        n0 = n_obs; s0 = seq;
        send(8'd9, 7, 1'b1, 1'b0);
        repeat (40) @(negedge clk);
        check(n_obs == n0, "R2", "words emitted before launch condition", n_obs - n0, 0);
        push(8'd9, 1'b0, 1'b1);
        wait_obs(n0 + 8);
        repeat (4) @(negedge clk);
        analyze(n0, 8, s0, 8'd9, 1'b1, 32, 1'b1, "R2");

        // R3: eager mode launches on a whole credit, and on a lone end-of-packet
        cfg_mode = 1'b0; cfg_burst_len = 10'd4;
        n0 = n_obs; s0 = seq;
        send(8'd10, 5, 1'b1, 1'b0);
        repeat (40) @(negedge clk);
        check(n_obs == n0, "R3", "words emitted below one credit", n_obs - n0, 0);
        send(8'd10, 3, 1'b0, 1'b0);
        wait_obs(n0 + 8);
        repeat (4) @(negedge clk);
        check(n_obs == n0 + 8, "R3", "credit burst word count", n_obs - n0, 8);
        analyze(n0, 8, s0, 8'd10, 1'b0, 32, 1'b0, "R3");
        n0 = n_obs; s0 = seq;
        push(8'd10, 1'b0, 1'b1);
        wait_obs(n0 + 1);
        repeat (4) @(negedge clk);
        check(n_obs == n0 + 1 && m_sob[n0] && m_eob[n0] && m_eop[n0], "R3",
              "single eop word burst flags (sob&eob&eop)",
              int'(m_sob[n0] && m_eob[n0] && m_eop[n0]), 1);

        // R8: channel change closes the old channel's buffered data
        cfg_mode = 1'b1; cfg_burst_len = 10'd4;
        n0 = n_obs; s0 = seq;
        send(8'd11, 5, 1'b1, 1'b0);
        send(8'd12, 6, 1'b1, 1'b1);
        wait_obs(n0 + 11);
        repeat (4) @(negedge clk);
        analyze(n0, 5, s0, 8'd11, 1'b1, 32, 1'b0, "R8");
        analyze(n0 + 5, 6, s0 + 5, 8'd12, 1'b1, 32, 1'b1, "R8");

        // R9: full buffer blocks input and forces a launch
        cfg_mode = 1'b1; cfg_burst_len = 10'd1023;
        n0 = n_obs; s0 = seq;
        send(8'd13, 2047, 1'b1, 1'b0);
        check(n_obs == n0, "R9", "words emitted before buffer full", n_obs - n0, 0);
        in_data = 16'(seq); in_chan = 8'd13; in_sop = 1'b0; in_eop = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; seq = seq + 1;
        check(in_ready == 1'b0, "R9", "in_ready with full buffer", int'(in_ready), 0);
        wait_obs(n0 + 2048);
        repeat (4) @(negedge clk);
        analyze(n0, 2048, s0, 8'd13, 1'b1, 8184, 1'b0, "R9");
        n0 = n_obs; s0 = seq;
        push(8'd13, 1'b0, 1'b1);
        wait_obs(n0 + 1);
        repeat (4) @(negedge clk);
        analyze(n0, 1, s0, 8'd13, 1'b1, 8184, 1'b1, "R9");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule